// File: doc/BRIEF.md
# Sign-Magnitude Integer Adder

This block adds two integers held in sign-magnitude form and returns their sum in the same form, together with an overflow flag. The top bit of each word is the sign, with 0 meaning positive. The bits below it hold the magnitude. When the two signs agree, the block adds the magnitudes and keeps the common sign. When they differ, it subtracts the smaller magnitude from the larger and takes the sign of the operand with the larger magnitude.

No arithmetic operator is used for the sum. Every addition and subtraction runs through ripple chains of explicit full-adder cells: each sum bit is the XOR of the two inputs and the carry, and each next carry is the majority of the three. A subtraction adds the inverted subtrahend with a carry-in of 1. The carry out of that subtraction also serves as the magnitude comparison.

The result is registered once, behind a clock enable. Software-free datapaths can drop it into a pipeline stage. An asynchronous active-low reset clears the output, and its release is synchronised inside the block.

Top module: `smag_adder`

## Requirements
- R1: When both operand signs are 0, the sum magnitude is the sum of the operand magnitudes and the result sign is 0.
- R2: When both operand signs are 1 and the magnitude sum is nonzero, the magnitude is the sum of the operand magnitudes and the result sign is 1.
- R3: When the signs differ, the magnitude is the larger operand magnitude minus the smaller. The sign is that of the larger-magnitude operand, and the overflow flag stays 0.
- R4: A zero result magnitude is always returned with sign 0. This covers equal-and-opposite operands and negative-zero inputs, so a sign-1 zero (top bit 1, rest 0) never appears.
- R5: A like-sign addition whose magnitude sum exceeds the largest magnitude (2^(WIDTH-1) - 1) sets the overflow flag. The magnitude then returned is the sum modulo 2^(WIDTH-1).
- R6: The overflow flag is only ever set for an operation whose operands had equal signs.
- R7: The result and flag are registered. Operands presented with `en` high appear on `sum` and `ovf` after the next rising clock edge. While `en` is low, the outputs hold their value whatever the operands do.
- R8: While `rst_n` is low, `sum` and `ovf` are 0. They are cleared without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the result register |
| op_a | input | WIDTH | First operand, sign in top bit |
| op_b | input | WIDTH | Second operand, sign in top bit |
| sum | output | WIDTH | Sign-magnitude sum, registered |
| ovf | output | 1 | Like-sign magnitude overflow, registered |

## Verification
The bench builds the adder with WIDTH set to 8, which leaves 7 magnitude bits. At that width a signed-integer reference can cover the whole operand range. Full-scale operands, carry-out into a truncated zero, negative zero on either input and exact cancellation all fall within a handful of table rows, and a few hundred random pairs touch every sign combination many times.

// File: rtl/smag_pkg.sv
package smag_pkg;
  // Default operand width, sign bit included
  localparam int unsigned SMAG_DEF_WIDTH = 32;
endpackage

// File: rtl/smag_rst_sync.sv
module smag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/smag_rca.sv
module smag_rca #(
  parameter int unsigned N = 31
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         cin,
  output logic [N-1:0] s,
  output logic         cout
);
  logic [N:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (x[i] & c[i]) | (y[i] & c[i]);
  end

  assign cout = c[N];
endmodule

// File: rtl/smag_adder.sv
module smag_adder #(
  parameter int unsigned WIDTH = smag_pkg::SMAG_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum,
  output logic             ovf
);
  localparam int unsigned MW = WIDTH - 1;

  logic          rst_q_n;
  logic          sgn_a, sgn_b, like_sgn;
  logic [MW-1:0] mag_a, mag_b;
  logic [MW-1:0] add_mag, amb_mag, bma_mag;
  logic          add_co, a_ge_b, bma_co;
  logic [MW-1:0] mag_d;
  logic          sgn_d, ovf_d;
  logic [WIDTH-1:0] sum_q;
  logic          ovf_q;

  smag_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  assign sgn_a    = op_a[WIDTH-1];
  assign sgn_b    = op_b[WIDTH-1];
  assign mag_a    = op_a[MW-1:0];
  assign mag_b    = op_b[MW-1:0];
  assign like_sgn = ~(sgn_a ^ sgn_b);

  // magnitude sum
  smag_rca #(.N(MW)) u_add (.x(mag_a), .y(mag_b), .cin(1'b0),
                            .s(add_mag), .cout(add_co));
  // a - b; carry out high means mag_a >= mag_b
  smag_rca #(.N(MW)) u_amb (.x(mag_a), .y(~mag_b), .cin(1'b1),
                            .s(amb_mag), .cout(a_ge_b));
  // b - a
  smag_rca #(.N(MW)) u_bma (.x(mag_b), .y(~mag_a), .cin(1'b1),
                            .s(bma_mag), .cout(bma_co));

  // next-state
  always_comb begin
    if (like_sgn) begin
      mag_d = add_mag;
      sgn_d = sgn_a;
      ovf_d = add_co;
    end else if (a_ge_b) begin
      mag_d = amb_mag;
      sgn_d = sgn_a;
      ovf_d = 1'b0;
    end else begin
      mag_d = bma_mag;
      sgn_d = sgn_b;
      ovf_d = 1'b0;
    end
    if (mag_d == '0) sgn_d = 1'b0;
  end

  // register
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      sum_q <= {sgn_d, mag_d};
      ovf_q <= ovf_d;
    end
  end

  assign sum = sum_q;
  assign ovf = ovf_q;

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !en |=> ($stable(sum_q) && $stable(ovf_q)));

  // R4
  no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sum_q[MW-1:0] == '0) |-> !sum_q[WIDTH-1]);

  // R3
  unlike_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && (sgn_a != sgn_b)) |=> !ovf_q);

  // R6
  ovf_like_sgn_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && !like_sgn) |=> !ovf_q);

  // R1
  pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (en && !sgn_a && !sgn_b) |=> !sum_q[WIDTH-1]);

  // R3
  bma_borrow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mag_a != mag_b) |-> (a_ge_b != bma_co));
endmodule

// File: tb/smag_adder_bench.sv
module smag_adder_bench;
  localparam int W = 8;
  localparam int M = W - 1;
  localparam int NV = 16;

  // {op_a, op_b, expected sum, expected ovf}
  localparam logic [3*W:0] VEC [NV] = '{
    {8'h03, 8'h05, 8'h08, 1'b0},  // R1
    {8'h83, 8'h85, 8'h88, 1'b0},  // R2
    {8'h05, 8'h83, 8'h02, 1'b0},  // R3
    {8'h03, 8'h85, 8'h82, 1'b0},  // R3
    {8'h80, 8'h00, 8'h00, 1'b0},  // R4
    {8'h80, 8'h80, 8'h00, 1'b0},  // R4
    {8'h7F, 8'h7F, 8'h7E, 1'b1},  // R5
    {8'hFF, 8'hFF, 8'hFE, 1'b1},  // R5
    {8'h7F, 8'hFF, 8'h00, 1'b0},  // R4
    {8'h40, 8'h40, 8'h00, 1'b1},  // R5
    {8'hC0, 8'hC0, 8'h00, 1'b1},  // R5
    {8'h7F, 8'h02, 8'h01, 1'b1},  // R5
    {8'h85, 8'h03, 8'h82, 1'b0},  // R3
    {8'h01, 8'hFF, 8'hFE, 1'b0},  // R3
    {8'h80, 8'h05, 8'h05, 1'b0},  // R4
    {8'h85, 8'h80, 8'h85, 1'b0}   // R2
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] sum;
  logic         ovf;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smag_adder #(.WIDTH(W)) u_smag_adder (
    .clk(clk), .rst_n(rst_n), .en(en),
    .op_a(op_a), .op_b(op_b), .sum(sum), .ovf(ovf));

  function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b);
    int va, vb, s, am;
    logic [W-1:0] r;
    logic o;
    va = a[W-1] ? -int'(a[M-1:0]) : int'(a[M-1:0]);
    vb = b[W-1] ? -int'(b[M-1:0]) : int'(b[M-1:0]);
    s  = va + vb;
    am = (s < 0) ? -s : s;
    o  = (am > (1 << M) - 1);
    am = am % (1 << M);
    r  = {(s < 0) && (am != 0), am[M-1:0]};
    return {r, o};
  endfunction

  task automatic check(string req, logic [W-1:0] es, logic eo);
    n_run++;
    if (sum !== es || ovf !== eo) begin
      n_fail++;
      $display("FAIL %s: sum=%h ovf=%b expected sum=%h ovf=%b", req, sum, ovf, es, eo);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    op_a = a; op_b = b; en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W:0] e;
    repeat (3) @(negedge clk);
    check("R8", '0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][3*W:2*W+1], VEC[i][2*W:W+1]);
      check($sformatf("R1..R5 vec%0d", i), VEC[i][W:1], VEC[i][0]);
    end

    // R7: enable low holds the output
    apply(8'h10, 8'h22);
    check("R7", 8'h32, 1'b0);
    op_a = 8'hFF; op_b = 8'hFF; en = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", 8'h32, 1'b0);

    // R6 / R3: random pairs against the integer reference
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      e = ref_add(a, b);
      apply(a, b);
      check((a[W-1] == b[W-1]) ? "R1/R2/R5" : "R3/R6", e[W:1], e[0]);
    end

    // R8: asynchronous clear mid-run
    apply(8'h7F, 8'h7F);
    check("R5", 8'h7E, 1'b1);
    #1 rst_n = 1'b0;
    #1 check("R8", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(8'h81, 8'h80);
    check("R2", 8'h81, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule